// File: doc/BRIEF.md
# Cache control register sequencer

This block holds the 16-bit control word for an external second-level cache interface and guards the order in which software may change it. Each write passes through a legality filter before it lands. Turning the cache on needs a programmed clock divider and a locked delay-locked loop, and it cannot happen while an invalidate is still running. A global invalidate is refused while the cache is, or is being, switched on. The write-through mode cannot be raised once the cache is on. A refused field keeps its old value, the legal fields of the same write still land, and a sticky error flag records the refusal.

Around the register, the block issues a single-cycle invalidate pulse to the array clearing logic and holds the invalidate field high until the clearing logic reports completion. It moves the live cache enable only on transaction-accept strobes. When software has allowed it, it drives the RAM sleep pin from the nap and sleep state inputs. It also derives the allocation-lock policy and masks the generated parity when parity is off. The tag and data arrays, the bus interface and the DLL itself live elsewhere.

Top module: `cachectl_seq`

## Requirements
- R1: After reset the register reads 0x0000 and cache_en, inv_pulse, ram_zz, cfg_err, wt_mode and alloc_lock are all 0.
- R2: A legal write stores every field and rd_data returns it. Field positions: bit 0 enable, bit 1 parity on, bits 3:2 size, bits 6:4 clock divider (000 = clock off), bits 8:7 RAM type, bit 9 data-only, bit 10 invalidate, bit 11 sleep-pin control, bit 12 write-through, bit 13 test, bits 15:14 output hold.
- R3: A write that raises bit 0 is accepted only if the stored bits 6:4 are nonzero, dll_locked is 1 and the stored bit 10 is 0. Otherwise bit 0 stays 0.
- R4: cache_en takes the stored bit 0 on each cycle in which xact_accept is 1, and keeps its value at every other cycle. It changes one cycle after the strobe.
- R5: A write with bit 10 set is refused when the stored bit 0 or the written bit 0 is 1.
- R6: An accepted invalidate sets bit 10 and gives inv_pulse high for exactly the one cycle after the write. Writing 0 to bit 10 does not clear it. Bit 10 clears one cycle after inv_done is seen high.
- R7: Bit 12 cannot go from 0 to 1 while the stored bit 0 is 1. It may be cleared at any time.
- R8: Only the refused field keeps its old value. The other fields of that write are stored, and cfg_err goes to 1 and stays 1 until reset.
- R9: ram_zz is 1 one cycle after a cycle in which bit 11 is 1 and nap or sleep is 1. Otherwise it is 0 one cycle later.
- R10: alloc_lock is 1 exactly while bit 9 and iside_only are both 1. wt_mode follows bit 12.
- R11: par_out equals par_in while bit 1 is 1 and is all zeros while bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register contents |
| dll_locked | input | 1 | DLL reports stable lock |
| xact_accept | input | 1 | Transaction-accept strobe |
| inv_done | input | 1 | Array clearing finished |
| nap | input | 1 | Device in nap state |
| sleep | input | 1 | Device in sleep state |
| iside_only | input | 1 | Instruction-only policy from a neighbouring register |
| par_in | input | PAR_W | Raw generated parity |
| cache_en | output | 1 | Live cache enable |
| inv_pulse | output | 1 | One-cycle invalidate start |
| wt_mode | output | 1 | Write-through mode |
| alloc_lock | output | 1 | Misses allocate nothing; write hits still update |
| ram_zz | output | 1 | RAM sleep pin |
| cfg_err | output | 1 | Sticky refused-write flag |
| par_out | output | PAR_W | Parity after masking |

## Verification
The assertions check the following on every cycle:
- the enable cannot rise without lock;
- the live enable moves only on a strobe;
- an invalidate written while enabled is refused;
- the invalidate pulse lasts one cycle and comes with the invalidate field set;
- write-through cannot rise while enabled;
- the error flag is sticky;
- the sleep-pin latency holds;
- parity is masked.

Only the bench scenarios can show that a refused write still stores its legal fields. They also show that completion clears the invalidate field, that enable is refused during an invalidate, and that write-through may be raised again once the cache is off.

// File: rtl/cachectl_pkg.sv
`timescale 1ns/1ps
package cachectl_pkg;
    localparam int CFG_W     = 16;
    localparam int B_EN      = 0;
    localparam int B_PAR     = 1;
    localparam int B_CLK_LO  = 4;
    localparam int B_CLK_HI  = 6;
    localparam int B_DONLY   = 9;
    localparam int B_INV     = 10;
    localparam int B_ZZ      = 11;
    localparam int B_WT      = 12;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             live_en;
        logic             inv_pulse;
        logic             zz;
        logic             err;
    } seq_state_t;
endpackage

// File: rtl/cachectl_wrfilt.sv
`timescale 1ns/1ps
module cachectl_wrfilt
    import cachectl_pkg::*;
(
    input  logic [CFG_W-1:0] cur,
    input  logic [CFG_W-1:0] wdata,
    input  logic             wr_en,
    input  logic             dll_locked,
    output logic [CFG_W-1:0] nxt,
    output logic             reject,
    output logic             inv_start
);
    logic ratio_set;
    logic en_ok;

    assign ratio_set = |cur[B_CLK_HI:B_CLK_LO];
    assign en_ok     = ratio_set && dll_locked && !cur[B_INV];

    always_comb begin
        nxt       = cur;
        reject    = 1'b0;
        inv_start = 1'b0;
        if (wr_en) begin
            nxt        = wdata;
            nxt[B_INV] = cur[B_INV];
            // invalidate: refused while enabled or being enabled
            if (wdata[B_INV]) begin
                if (cur[B_EN] || wdata[B_EN]) begin
                    reject = 1'b1;
                end else if (!cur[B_INV]) begin
                    nxt[B_INV] = 1'b1;
                    inv_start  = 1'b1;
                end
            end
            // enable: needs divider, lock and no pending invalidate
            if (wdata[B_EN] && !cur[B_EN] && !en_ok) begin
                nxt[B_EN] = 1'b0;
                reject    = 1'b1;
            end
            // write-through frozen while enabled
            if (wdata[B_WT] && !cur[B_WT] && cur[B_EN]) begin
                nxt[B_WT] = 1'b0;
                reject    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cachectl_zzctl.sv
`timescale 1ns/1ps
module cachectl_zzctl (
    input  logic zz_allow,
    input  logic nap,
    input  logic sleep,
    output logic zz_want
);
    logic low_power;
    assign low_power = nap | sleep;
    assign zz_want   = zz_allow & low_power;
endmodule

// File: rtl/cachectl_policy.sv
`timescale 1ns/1ps
module cachectl_policy #(
    parameter int PAR_W = 8
) (
    input  logic             par_on,
    input  logic             data_only,
    input  logic             wt_bit,
    input  logic             iside_only,
    input  logic [PAR_W-1:0] par_in,
    output logic [PAR_W-1:0] par_out,
    output logic             alloc_lock,
    output logic             wt_mode
);
    assign alloc_lock = data_only & iside_only;
    assign wt_mode    = wt_bit;

    for (genvar i = 0; i < PAR_W; i++) begin : g_par
        assign par_out[i] = par_in[i] & par_on;
    end
endmodule

// File: rtl/cachectl_seq.sv
`timescale 1ns/1ps
module cachectl_seq
    import cachectl_pkg::*;
#(
    parameter int PAR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    output logic [15:0]      rd_data,
    input  logic             dll_locked,
    input  logic             xact_accept,
    input  logic             inv_done,
    input  logic             nap,
    input  logic             sleep,
    input  logic             iside_only,
    input  logic [PAR_W-1:0] par_in,
    output logic             cache_en,
    output logic             inv_pulse,
    output logic             wt_mode,
    output logic             alloc_lock,
    output logic             ram_zz,
    output logic             cfg_err,
    output logic [PAR_W-1:0] par_out
);
    seq_state_t s_d, s_q;

    logic [CFG_W-1:0] filt_nxt;
    logic             filt_reject;
    logic             filt_inv_start;
    logic             zz_want;

    cachectl_wrfilt u_filt (
        .cur        (s_q.cfg),
        .wdata      (wr_data),
        .wr_en      (wr_en),
        .dll_locked (dll_locked),
        .nxt        (filt_nxt),
        .reject     (filt_reject),
        .inv_start  (filt_inv_start)
    );

    cachectl_zzctl u_zz (
        .zz_allow (s_q.cfg[B_ZZ]),
        .nap      (nap),
        .sleep    (sleep),
        .zz_want  (zz_want)
    );

    cachectl_policy #(.PAR_W(PAR_W)) u_pol (
        .par_on     (s_q.cfg[B_PAR]),
        .data_only  (s_q.cfg[B_DONLY]),
        .wt_bit     (s_q.cfg[B_WT]),
        .iside_only (iside_only),
        .par_in     (par_in),
        .par_out    (par_out),
        .alloc_lock (alloc_lock),
        .wt_mode    (wt_mode)
    );

    always_comb begin
        s_d           = s_q;
        s_d.cfg       = filt_nxt;
        if (inv_done && s_q.cfg[B_INV]) begin
            s_d.cfg[B_INV] = 1'b0;
        end
        s_d.inv_pulse = filt_inv_start;
        s_d.err       = s_q.err | filt_reject;
        s_d.zz        = zz_want;
        if (xact_accept) begin
            s_d.live_en = s_q.cfg[B_EN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data   = s_q.cfg;
    assign cache_en  = s_q.live_en;
    assign inv_pulse = s_q.inv_pulse;
    assign ram_zz    = s_q.zz;
    assign cfg_err   = s_q.err;
endmodule

// File: rtl/cachectl_chk.sv
`timescale 1ns/1ps
module cachectl_chk
    import cachectl_pkg::*;
#(
    parameter int PAR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [15:0]      wr_data,
    input logic [15:0]      rd_data,
    input logic             dll_locked,
    input logic             xact_accept,
    input logic             nap,
    input logic             sleep,
    input logic             cache_en,
    input logic             inv_pulse,
    input logic             ram_zz,
    input logic             cfg_err,
    input logic [PAR_W-1:0] par_out
);
    // R3
    en_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[B_EN] && !dll_locked) |=> !rd_data[B_EN]);

    // R4
    live_en_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xact_accept |=> $stable(cache_en));

    // R5
    no_inv_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_INV] && rd_data[B_EN] && !rd_data[B_INV]) |=> !rd_data[B_INV]);

    // R6
    inv_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_pulse |=> !inv_pulse);

    // R6
    inv_pulse_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_pulse |-> rd_data[B_INV]);

    // R7
    wt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_EN] && !rd_data[B_WT]) |=> !rd_data[B_WT]);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R9
    zz_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_ZZ] && (nap || sleep)) |=> ram_zz);

    // R9
    zz_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nap || sleep) |=> !ram_zz);

    // R11
    par_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[B_PAR] |-> (par_out == '0));
endmodule

bind cachectl_seq cachectl_chk #(.PAR_W(PAR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .dll_locked  (dll_locked),
    .xact_accept (xact_accept),
    .nap         (nap),
    .sleep       (sleep),
    .cache_en    (cache_en),
    .inv_pulse   (inv_pulse),
    .ram_zz      (ram_zz),
    .cfg_err     (cfg_err),
    .par_out     (par_out)
);

// File: tb/sim_cachectl_seq.sv
`timescale 1ns/1ps
module sim_cachectl_seq;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   rd_data;
    logic          dll_locked = 1'b0;
    logic          xact_accept = 1'b0;
    logic          inv_done = 1'b0;
    logic          nap = 1'b0;
    logic          sleep = 1'b0;
    logic          iside_only = 1'b0;
    logic [PW-1:0] par_in = '0;
    logic          cache_en, inv_pulse, wt_mode, alloc_lock, ram_zz, cfg_err;
    logic [PW-1:0] par_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cachectl_seq #(.PAR_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .dll_locked(dll_locked), .xact_accept(xact_accept), .inv_done(inv_done),
        .nap(nap), .sleep(sleep), .iside_only(iside_only), .par_in(par_in),
        .cache_en(cache_en), .inv_pulse(inv_pulse), .wt_mode(wt_mode),
        .alloc_lock(alloc_lock), .ram_zz(ram_zz), .cfg_err(cfg_err), .par_out(par_out)
    );

    // behavioural reference model
    logic [15:0] m_cfg;
    logic        m_live, m_pulse, m_zz, m_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg = '0; m_live = 0; m_pulse = 0; m_zz = 0; m_err = 0;
        end else begin
            logic [15:0] n;
            logic        refused, started;
            n = m_cfg; refused = 0; started = 0;
            if (wr_en) begin
                n = wr_data;
                n[10] = m_cfg[10];
                if (wr_data[10]) begin
                    if (m_cfg[0] == 1'b1 || wr_data[0] == 1'b1) refused = 1;
                    else if (m_cfg[10] == 1'b0) begin n[10] = 1; started = 1; end
                end
                if (wr_data[0] && !m_cfg[0]) begin
                    if (m_cfg[6:4] == 3'd0 || !dll_locked || m_cfg[10]) begin
                        n[0] = 0; refused = 1;
                    end
                end
                if (wr_data[12] && !m_cfg[12] && m_cfg[0]) begin
                    n[12] = 0; refused = 1;
                end
            end
            if (inv_done && m_cfg[10]) n[10] = 0;
            m_pulse = started;
            if (refused) m_err = 1;
            m_zz = m_cfg[11] && (nap || sleep);
            if (xact_accept) m_live = m_cfg[0];
            m_cfg = n;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 rd_data model", {16'd0, rd_data}, {16'd0, m_cfg});
            chk("R4 cache_en model", {31'd0, cache_en}, {31'd0, m_live});
            chk("R6 inv_pulse model", {31'd0, inv_pulse}, {31'd0, m_pulse});
            chk("R9 ram_zz model", {31'd0, ram_zz}, {31'd0, m_zz});
            chk("R8 cfg_err model", {31'd0, cfg_err}, {31'd0, m_err});
            chk("R10 alloc_lock model", {31'd0, alloc_lock}, {31'd0, m_cfg[9] & iside_only});
            chk("R10 wt_mode model", {31'd0, wt_mode}, {31'd0, m_cfg[12]});
            chk("R11 par_out model", {24'd0, par_out}, {24'd0, (m_cfg[1] ? par_in : 8'h00)});
        end
    end

    task automatic step();
        @(posedge clk); #5;
    endtask

    task automatic wr(logic [15:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        chk("R1 rd_data reset", {16'd0, rd_data}, 32'h0);
        chk("R1 outputs reset", {26'd0, cache_en, inv_pulse, ram_zz, cfg_err, wt_mode, alloc_lock}, 32'h0);
        rst_n = 1'b1;
        step();

        wr(16'h0001);                                   // divider still zero
        chk("R3 enable without divider", {31'd0, rd_data[0]}, 32'h0);
        chk("R8 error raised", {31'd0, cfg_err}, 32'h1);

        wr(16'h011E);
        chk("R2 legal write", {16'd0, rd_data}, 32'h011E);

        wr(16'h011F);                                   // no lock yet
        chk("R3 enable without lock", {16'd0, rd_data}, 32'h011E);

        dll_locked = 1'b1;
        wr(16'h051E);
        chk("R6 invalidate accepted", {16'd0, rd_data}, 32'h051E);
        chk("R6 pulse high", {31'd0, inv_pulse}, 32'h1);
        step();
        chk("R6 pulse one cycle", {31'd0, inv_pulse}, 32'h0);

        wr(16'h011F);                                   // enable during invalidate
        chk("R3 enable during invalidate", {16'd0, rd_data}, 32'h051E);

        inv_done = 1'b1; step(); inv_done = 1'b0;
        chk("R6 cleared by done", {16'd0, rd_data}, 32'h011E);

        wr(16'h011F);
        chk("R3 enable accepted", {16'd0, rd_data}, 32'h011F);
        chk("R4 no strobe yet", {31'd0, cache_en}, 32'h0);
        step(); step();
        chk("R4 still waiting", {31'd0, cache_en}, 32'h0);
        xact_accept = 1'b1; step(); xact_accept = 1'b0;
        chk("R4 live after strobe", {31'd0, cache_en}, 32'h1);

        wr(16'h191F);                                   // write-through + sleep ctl
        chk("R7 wt refused, R8 zz kept", {16'd0, rd_data}, 32'h091F);

        wr(16'h0D1F);                                   // invalidate while on
        chk("R5 invalidate refused", {16'd0, rd_data}, 32'h091F);

        nap = 1'b1; step();
        chk("R9 zz on nap", {31'd0, ram_zz}, 32'h1);
        nap = 1'b0; sleep = 1'b1; step();
        chk("R9 zz on sleep", {31'd0, ram_zz}, 32'h1);
        sleep = 1'b0; step();
        chk("R9 zz off on exit", {31'd0, ram_zz}, 32'h0);

        wr(16'h0B1F);
        iside_only = 1'b1; #1;
        chk("R10 lock both set", {31'd0, alloc_lock}, 32'h1);
        iside_only = 1'b0; #1;
        chk("R10 lock one set", {31'd0, alloc_lock}, 32'h0);

        par_in = 8'hA5; #1;
        chk("R11 parity passes", {24'd0, par_out}, 32'hA5);
        wr(16'h0B1D);
        chk("R11 parity masked", {24'd0, par_out}, 32'h0);

        wr(16'h0B1C);
        wr(16'h1B1C);
        chk("R7 wt allowed when off", {16'd0, rd_data}, 32'h1B1C);
        xact_accept = 1'b1; step(); xact_accept = 1'b0;
        chk("R4 live off after strobe", {31'd0, cache_en}, 32'h0);

        wr(16'h131C);
        nap = 1'b1; step(); step();
        chk("R9 zz held low when disallowed", {31'd0, ram_zz}, 32'h0);
        nap = 1'b0;
        chk("R8 error still sticky", {31'd0, cfg_err}, 32'h1);
        step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule